// File: doc/BRIEF.md
# Character Window Raster Position Generator

This block tracks where the video beam is, relative to the incoming line and frame sync strobes, and turns that position into the coordinates an on-screen text overlay needs. It counts dot-clock enables along each line and scan lines down each frame. It opens a window of 24 character columns by 10 character rows, with each character cell 8 by 8 dots. For every dot it gives the display-memory character address as a row and a column. It also gives the font row and font column inside the cell, and a flag that marks dots inside the window.

The window origin is set by two coarse 6-bit offsets, each counted in steps of two: two scan lines per step vertically and two dot clocks per step horizontally. Each axis can stretch a dot to two lines or two dot clocks. The top character row has its own pair of size bits and all lower rows share a second pair, so a large title row can sit above normal text. Offsets and size bits are sampled when a frame strobe arrives, so the geometry never changes part way through a frame. The character address runs one dot ahead of the font indices and the window flag, which leaves a cycle for a registered character-memory read.

Top module: `osd_raster_gen`

## Requirements
- R1: Character rows run 0 to 9 and character columns 0 to 23, each cell 8 dots wide and 8 dot rows tall; `ramRow` never exceeds 9 and `ramCol` never exceeds 23. Scan lines below the tenth character row and dots right of the 24th column are outside the window.
- R2: A frame strobe makes the current line number 0, and each later line strobe adds one. The window's first scan line is line 2 × `vStart`.
- R3: A line strobe makes the current dot number 0, and each later dot enable adds one. The window's first dot is dot 2 × `hStart`.
- R4: A dot row takes 2 scan lines when its size bit is 1 and 1 scan line when it is 0. `vDblFirst` applies to character row 0 and `vDblRest` applies to rows 1 to 9.
- R5: A dot column takes 2 dot enables when its size bit is 1 and 1 when it is 0. `hDblFirst` applies on character row 0 and `hDblRest` on rows 1 to 9.
- R6: A character column whose last dot would lie beyond dot `LINE_DOTS`−1 (default 320 dots, counted from the line strobe) keeps `winActive` low for its whole width. The column address still advances across it.
- R7: While `dispOn` is 0, `winActive` is 0, and it follows `dispOn` without waiting for a clock edge.
- R8: After reset, all outputs are 0, and the sampled offsets and size bits are 0 until the first frame strobe.
- R9: Offsets and size bits are sampled only in a cycle with `vsyncStb` high, and they take effect in that same cycle. Changes made between frame strobes have no effect.
- R10: `ramRow` and `ramCol` address the current dot. `fontRow`, `fontCol` and `winActive` describe the dot one dot enable earlier. A line strobe clears the window flag. When a line strobe and a dot enable fall in the same cycle, the line strobe wins and the dot is not counted. When a frame strobe and a line strobe fall in the same cycle, the frame strobe wins and the line is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dotEn | input | 1 | One-cycle enable per dot clock |
| hsyncStb | input | 1 | One-cycle line start strobe |
| vsyncStb | input | 1 | One-cycle frame start strobe |
| dispOn | input | 1 | Window enable; 0 forces `winActive` low |
| vStart | input | 6 | Vertical offset, in units of two scan lines |
| hStart | input | 6 | Horizontal offset, in units of two dot clocks |
| vDblFirst | input | 1 | Double height for character row 0 |
| vDblRest | input | 1 | Double height for character rows 1 to 9 |
| hDblFirst | input | 1 | Double width on character row 0 |
| hDblRest | input | 1 | Double width on character rows 1 to 9 |
| ramRow | output | 4 | Character row address of the current dot |
| ramCol | output | 5 | Character column address of the current dot |
| fontRow | output | 3 | Dot row in the cell, for the previous dot |
| fontCol | output | 3 | Dot column in the cell, for the previous dot |
| winActive | output | 1 | Previous dot lies in the window and display is on |

## Verification
The assertions rely on each sync strobe lasting a single cycle. They also rely on line and font positions moving only on a dot enable, a line strobe or a frame strobe, so that any other cycle must leave the addresses and font indices unchanged. The stimulus raises each strobe for exactly one cycle with `dotEn` held low, except in the single test that overlaps a line strobe with a dot enable to show that the strobe wins. Every frame is entered through a combined frame-and-line strobe, so both axes start from a known origin before any dot is counted.

// File: rtl/osd_raster_pkg.sv
package osd_raster_pkg;

  localparam int OSD_COLS      = 24;
  localparam int OSD_ROWS      = 10;
  localparam int OSD_CELL_DOTS = 8;
  localparam int OSD_START_W   = 6;

  // Strobes from the control side to the counters.
  typedef struct packed {
    logic vRestart;   // frame start
    logic lineStep;   // next scan line
    logic hRestart;   // line start
    logic dotStep;    // next dot
  } osdStrobe_t;

  // Geometry in effect for the current frame.
  typedef struct packed {
    logic [OSD_START_W-1:0] vStart;
    logic [OSD_START_W-1:0] hStart;
    logic                   vDblFirst;
    logic                   vDblRest;
    logic                   hDblFirst;
    logic                   hDblRest;
  } osdCfg_t;

endpackage

// File: rtl/osd_axis_track.sv
// One axis of the window: position counter, start match, size repeat,
// dot index inside a cell and cell index inside the window.
module osd_axis_track #(
  parameter int CELLS     = 24,
  parameter int CELL_DOTS = 8,
  parameter int START_W   = 6,
  localparam int POS_W    = START_W + 1,
  localparam int CELL_W   = $clog2(CELLS),
  localparam int DOT_W    = $clog2(CELL_DOTS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               restart,
  input  logic               step,
  input  logic [START_W-1:0] startUnits,
  input  logic               dbl,
  output logic               act,
  output logic [CELL_W-1:0]  cellIdx,
  output logic [DOT_W-1:0]   dotIdx
);

  localparam logic [POS_W-1:0]  POS_MAX   = {POS_W{1'b1}};
  localparam logic [CELL_W-1:0] CELL_LAST = CELL_W'(CELLS - 1);
  localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(CELL_DOTS - 1);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] posNext;
  logic [POS_W-1:0] startPos;
  logic             done;
  logic             rep;

  assign startPos = {startUnits, 1'b0};
  assign posNext  = (pos == POS_MAX) ? pos : pos + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos     <= '0;
      act     <= 1'b0;
      done    <= 1'b0;
      rep     <= 1'b0;
      dotIdx  <= '0;
      cellIdx <= '0;
    end else if (restart) begin
      pos     <= '0;
      act     <= (startUnits == '0);
      done    <= 1'b0;
      rep     <= 1'b0;
      dotIdx  <= '0;
      cellIdx <= '0;
    end else if (step) begin
      pos <= posNext;
      if (!act && !done && (posNext == startPos)) begin
        act     <= 1'b1;
        rep     <= 1'b0;
        dotIdx  <= '0;
        cellIdx <= '0;
      end else if (act) begin
        if (dbl && !rep) begin
          rep <= 1'b1;
        end else begin
          rep    <= 1'b0;
          dotIdx <= dotIdx + 1'b1;
          if (dotIdx == DOT_LAST) begin
            if (cellIdx == CELL_LAST) begin
              act  <= 1'b0;
              done <= 1'b1;
            end else begin
              cellIdx <= cellIdx + 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/osd_raster_ctl.sv
// Strobe priority and per-frame geometry capture.
module osd_raster_ctl
  import osd_raster_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dotEn,
  input  logic       hsyncStb,
  input  logic       vsyncStb,
  input  osdCfg_t    cfgIn,
  output osdStrobe_t stb,
  output osdCfg_t    cfgEff
);

  osdCfg_t cfgR;

  always_comb begin
    stb.vRestart = vsyncStb;
    stb.lineStep = hsyncStb & ~vsyncStb;
    stb.hRestart = hsyncStb;
    stb.dotStep  = dotEn & ~hsyncStb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgR <= '0;
    else if (vsyncStb) cfgR <= cfgIn;
  end

  // The frame strobe cycle already uses the geometry being captured.
  assign cfgEff = vsyncStb ? cfgIn : cfgR;

endmodule

// File: rtl/osd_raster_dp.sv
// Both axis trackers, right-edge fit test and the font-side stage.
module osd_raster_dp
  import osd_raster_pkg::*;
#(
  parameter int COLS      = OSD_COLS,
  parameter int ROWS      = OSD_ROWS,
  parameter int CELL_DOTS = OSD_CELL_DOTS,
  parameter int LINE_DOTS = 320,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int COL_W    = $clog2(COLS),
  localparam int DOT_W    = $clog2(CELL_DOTS),
  localparam int SPAN_MAX = 2 * (2**OSD_START_W - 1) + COLS * 2 * CELL_DOTS,
  localparam int EDGE_W   = $clog2(SPAN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  osdStrobe_t       stb,
  input  osdCfg_t          cfg,
  input  logic             dispOn,
  output logic [ROW_W-1:0] ramRow,
  output logic [COL_W-1:0] ramCol,
  output logic [DOT_W-1:0] fontRow,
  output logic [DOT_W-1:0] fontCol,
  output logic             winActive
);

  logic             vAct, hAct;
  logic [ROW_W-1:0] vCell;
  logic [COL_W-1:0] hCell;
  logic [DOT_W-1:0] vDot, hDot;
  logic             topRow, vDbl, hDbl;
  logic             colFits, leadAct, winActR;
  logic [EDGE_W-1:0] colNum, cellWidth, endDot;

  assign topRow = (vCell == '0);
  assign vDbl   = topRow ? cfg.vDblFirst : cfg.vDblRest;
  assign hDbl   = topRow ? cfg.hDblFirst : cfg.hDblRest;

  osd_axis_track #(
    .CELLS(ROWS), .CELL_DOTS(CELL_DOTS), .START_W(OSD_START_W)
  ) u_vTrack (
    .clk(clk), .rstN(rstN),
    .restart(stb.vRestart), .step(stb.lineStep),
    .startUnits(cfg.vStart), .dbl(vDbl),
    .act(vAct), .cellIdx(vCell), .dotIdx(vDot)
  );

  osd_axis_track #(
    .CELLS(COLS), .CELL_DOTS(CELL_DOTS), .START_W(OSD_START_W)
  ) u_hTrack (
    .clk(clk), .rstN(rstN),
    .restart(stb.hRestart), .step(stb.dotStep),
    .startUnits(cfg.hStart), .dbl(hDbl),
    .act(hAct), .cellIdx(hCell), .dotIdx(hDot)
  );

  // Right edge of the current column, measured from the line strobe.
  always_comb begin
    colNum    = EDGE_W'(hCell) + EDGE_W'(1);
    cellWidth = hDbl ? EDGE_W'(2 * CELL_DOTS) : EDGE_W'(CELL_DOTS);
    endDot    = EDGE_W'({cfg.hStart, 1'b0}) + colNum * cellWidth;
    colFits   = (endDot <= EDGE_W'(LINE_DOTS));
  end

  assign leadAct = vAct & hAct & colFits;

  // Font side lags the address side by one dot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fontRow <= '0;
      fontCol <= '0;
      winActR <= 1'b0;
    end else if (stb.hRestart) begin
      winActR <= 1'b0;
    end else if (stb.dotStep) begin
      fontRow <= vDot;
      fontCol <= hDot;
      winActR <= leadAct;
    end
  end

  assign ramRow    = vCell;
  assign ramCol    = hCell;
  assign winActive = winActR & dispOn;

endmodule

// File: rtl/osd_raster_gen.sv
module osd_raster_gen
  import osd_raster_pkg::*;
#(
  parameter int COLS      = OSD_COLS,
  parameter int ROWS      = OSD_ROWS,
  parameter int CELL_DOTS = OSD_CELL_DOTS,
  parameter int LINE_DOTS = 320,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int COL_W    = $clog2(COLS),
  localparam int DOT_W    = $clog2(CELL_DOTS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dotEn,
  input  logic                   hsyncStb,
  input  logic                   vsyncStb,
  input  logic                   dispOn,
  input  logic [OSD_START_W-1:0] vStart,
  input  logic [OSD_START_W-1:0] hStart,
  input  logic                   vDblFirst,
  input  logic                   vDblRest,
  input  logic                   hDblFirst,
  input  logic                   hDblRest,
  output logic [ROW_W-1:0]       ramRow,
  output logic [COL_W-1:0]       ramCol,
  output logic [DOT_W-1:0]       fontRow,
  output logic [DOT_W-1:0]       fontCol,
  output logic                   winActive
);

  osdStrobe_t stb;
  osdCfg_t    cfgIn, cfgEff;

  assign cfgIn = '{vStart: vStart, hStart: hStart,
                   vDblFirst: vDblFirst, vDblRest: vDblRest,
                   hDblFirst: hDblFirst, hDblRest: hDblRest};

  osd_raster_ctl u_ctl (
    .clk(clk), .rstN(rstN), .dotEn(dotEn),
    .hsyncStb(hsyncStb), .vsyncStb(vsyncStb),
    .cfgIn(cfgIn), .stb(stb), .cfgEff(cfgEff)
  );

  osd_raster_dp #(
    .COLS(COLS), .ROWS(ROWS), .CELL_DOTS(CELL_DOTS), .LINE_DOTS(LINE_DOTS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfgEff), .dispOn(dispOn),
    .ramRow(ramRow), .ramCol(ramCol),
    .fontRow(fontRow), .fontCol(fontCol), .winActive(winActive)
  );

endmodule

// File: rtl/osd_raster_chk.sv
module osd_raster_chk #(
  parameter int COLS = 24,
  parameter int ROWS = 10,
  parameter int ROW_W = 4,
  parameter int COL_W = 5,
  parameter int DOT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             dotEn,
  input logic             hsyncStb,
  input logic             vsyncStb,
  input logic             dispOn,
  input logic [ROW_W-1:0] ramRow,
  input logic [COL_W-1:0] ramCol,
  input logic [DOT_W-1:0] fontRow,
  input logic [DOT_W-1:0] fontCol,
  input logic             winActive
);

  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ramRow <= ROW_W'(ROWS - 1)); // R1

  AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ramCol <= COL_W'(COLS - 1)); // R1

  AST_OFF_NO_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    winActive |-> dispOn); // R7

  AST_LINE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    hsyncStb |=> !winActive); // R10

  AST_FONT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!dotEn && !hsyncStb && !vsyncStb) |=> ($stable(fontRow) && $stable(fontCol))); // R10

  AST_ADDR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!dotEn && !hsyncStb && !vsyncStb) |=> ($stable(ramRow) && $stable(ramCol))); // R10

endmodule

bind osd_raster_gen osd_raster_chk #(
  .COLS(COLS), .ROWS(ROWS), .ROW_W(ROW_W), .COL_W(COL_W), .DOT_W(DOT_W)
) u_chk (.*);

// File: tb/tb_osd_raster_gen.sv
module tb_osd_raster_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dotEn = 1'b0, hsyncStb = 1'b0, vsyncStb = 1'b0, dispOn = 1'b1;
  logic [5:0] vStart = '0, hStart = '0;
  logic       vDblFirst = 1'b0, vDblRest = 1'b0, hDblFirst = 1'b0, hDblRest = 1'b0;
  logic [3:0] ramRow;
  logic [4:0] ramCol;
  logic [2:0] fontRow, fontCol;
  logic       winActive;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  osd_raster_gen dut (.*);

  typedef struct packed {
    logic [5:0] vs;
    logic [5:0] hs;
    logic       vf, vr, hf, hr;
    logic [7:0] line;
    logic [9:0] dots;
    logic       expAct;
    logic [3:0] expRow;
    logic [4:0] expCol;
    logic [2:0] expFRow;
    logic [2:0] expFCol;
    logic       chkAddr;
  } vec_t;

  // line: strobes after frame start; dots: enables after the last line strobe.
  // Address fields refer to dot "dots", font fields and flag to dot "dots"-1.
  localparam vec_t VECS [0:8] = '{
    '{6'd1, 6'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2,  10'd5,   1'b1, 4'd0, 5'd0,  3'd0, 3'd0, 1'b1}, // R2 R3 first dot
    '{6'd1, 6'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3,  10'd4,   1'b0, 4'd0, 5'd0,  3'd0, 3'd0, 1'b1}, // R3 just before edge
    '{6'd1, 6'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd11, 10'd21,  1'b1, 4'd1, 5'd2,  3'd1, 3'd0, 1'b1}, // R1 R2 R3 inner cell
    '{6'd1, 6'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd81, 10'd196, 1'b1, 4'd9, 5'd0,  3'd7, 3'd7, 1'b0}, // R1 last dot
    '{6'd1, 6'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd82, 10'd10,  1'b0, 4'd0, 5'd0,  3'd0, 3'd0, 1'b0}, // R1 below row 9
    '{6'd0, 6'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd15, 10'd17,  1'b1, 4'd0, 5'd1,  3'd7, 3'd0, 1'b1}, // R4 R5 big top row
    '{6'd0, 6'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd16, 10'd9,   1'b1, 4'd1, 5'd1,  3'd0, 3'd0, 1'b1}, // R4 R5 normal row 1
    '{6'd0, 6'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd10, 10'd321, 1'b0, 4'd1, 5'd20, 3'd0, 3'd0, 1'b1}, // R6 suppressed col
    '{6'd0, 6'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd10, 10'd320, 1'b1, 4'd1, 5'd20, 3'd1, 3'd7, 1'b1}  // R6 last fitting col
  };

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseLine();
    hsyncStb = 1'b1;
    @(negedge clk);
    hsyncStb = 1'b0;
  endtask

  task automatic runDots(int k);
    for (int i = 0; i < k; i++) begin
      dotEn = 1'b1;
      @(negedge clk);
    end
    dotEn = 1'b0;
  endtask

  // Frame and line strobe together, n more line strobes, then k dot enables.
  task automatic goTo(int n, int k);
    @(negedge clk);
    vsyncStb = 1'b1; hsyncStb = 1'b1; dotEn = 1'b0;
    @(negedge clk);
    vsyncStb = 1'b0; hsyncStb = 1'b0;
    for (int i = 0; i < n; i++) pulseLine();
    runDots(k);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: outputs after reset
    chk("R8 reset ramRow", ramRow, 0);
    chk("R8 reset ramCol", ramCol, 0);
    chk("R8 reset fontRow", fontRow, 0);
    chk("R8 reset fontCol", fontCol, 0);
    chk("R8 reset winActive", winActive, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R8: without a frame strobe the vertical window never opens
    hStart = 6'd5; vStart = 6'd0;
    pulseLine();
    runDots(3);
    chk("R8 no frame yet winActive", winActive, 0);

    for (int i = 0; i < 9; i++) begin
      vec_t v;
      v = VECS[i];
      vStart = v.vs; hStart = v.hs;
      vDblFirst = v.vf; vDblRest = v.vr; hDblFirst = v.hf; hDblRest = v.hr;
      goTo(int'(v.line), int'(v.dots));
      chk($sformatf("R2 R3 R4 R5 R6 vec%0d winActive", i), winActive, v.expAct);
      if (v.expAct) begin
        chk($sformatf("R10 vec%0d fontRow", i), fontRow, v.expFRow);
        chk($sformatf("R10 vec%0d fontCol", i), fontCol, v.expFCol);
      end
      if (v.chkAddr) begin
        chk($sformatf("R1 vec%0d ramRow", i), ramRow, v.expRow);
        chk($sformatf("R1 vec%0d ramCol", i), ramCol, v.expCol);
      end else if (i == 3) begin
        chk("R1 vec3 ramRow", ramRow, 9);
      end
    end

    // R7: display off hides an active dot, and the flag follows dispOn at once
    vStart = 6'd1; hStart = 6'd2;
    vDblFirst = 1'b0; vDblRest = 1'b0; hDblFirst = 1'b0; hDblRest = 1'b0;
    dispOn = 1'b0;
    goTo(2, 5);
    chk("R7 off winActive", winActive, 0);
    dispOn = 1'b1;
    #1;
    chk("R7 back on winActive", winActive, 1);

    // R9: a new offset between frame strobes is ignored
    goTo(2, 5);
    hStart = 6'd10;
    pulseLine();
    runDots(5);
    chk("R9 old offset still used", winActive, 1);
    chk("R9 old offset fontCol", fontCol, 0);
    goTo(2, 5);
    chk("R9 new offset after frame", winActive, 0);

    // R10: line strobe wins over a dot enable in the same cycle
    hStart = 6'd2;
    goTo(2, 5);
    @(negedge clk);
    hsyncStb = 1'b1; dotEn = 1'b1;
    @(negedge clk);
    hsyncStb = 1'b0;
    runDots(5);
    chk("R10 strobe priority winActive", winActive, 1);
    chk("R10 strobe priority fontCol", fontCol, 0);
    chk("R10 lead address ramCol", ramCol, 0);

    // R10: line strobe clears the flag
    pulseLine();
    chk("R10 line strobe clears flag", winActive, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule